// File: doc/BRIEF.md
# Block Transpose Buffer with Alternating Frame Stores

This block reorders a frame of fixed-size data blocks between two orderings. The first is codeword order, where the 99 blocks of one component codeword arrive back to back. The second is segment order, where segment j carries block j of each of the 60 codewords, one after another. In segment order, neighbouring blocks never belong to the same codeword. A burst of channel errors that covers up to 60 neighbouring blocks is therefore spread over 60 different codewords, one block each. Each block is 18 bits wide. A frame is 5940 blocks.

Blocks enter through a write port, one per cycle, with a frame-start marker on the first block of a frame. The block writes each block to a scattered address in one of two frame stores. It then streams the completed frame out of that store in plain address order, under a valid/ready handshake. A mode input chooses the scatter pattern. In transmit mode, codeword-order input is turned into segment order. In receive mode, segment-order input is rebuilt into codeword order. The two stores swap roles at each frame boundary, so the next frame can be written while the previous one is drained. If a new frame is offered while both stores still hold unread frames, that frame is refused and flagged.

Top module: `blkx_pingpong`

## Requirements
- R1: After reset, rd_valid, rd_last and ovr are all low.
- R2: With mode = 0 (transmit), the input block at frame position k = i*99 + j (codeword i in 0..59, block j in 0..98) is delivered at output position j*60 + i of that frame.
- R3: With mode = 1 (receive), the input block at frame position k = j*60 + i is delivered at output position i*99 + j.
- R4: rd_valid stays low while a frame is being written into an empty pair of stores. It rises in the cycle after the frame's 5940th block is written.
- R5: rd_last is high on output position 5939 of every frame, and low on every other transfer.
- R6: While rd_valid is high and rd_ready is low, rd_valid stays high and rd_data holds its value. Each cycle with both high moves the output to the next block.
- R7: A block presented with wr_valid high and wr_sof low while no frame is being filled is discarded. A block with wr_sof high opens a frame at position 0.
- R8: A block with wr_sof high that arrives in the middle of a frame restarts that frame at position 0, in the same store. The partial frame is dropped.
- R9: Frames are delivered whole, in the order they were written. A frame can be written into one store while the other store is being read.
- R10: A frame start offered while both stores hold undelivered frames raises ovr for exactly one cycle, in the cycle after the start. The blocks of that refused frame are never delivered, and the stored frames come out intact.
- R11: The mode is taken from the block that carries wr_sof and holds for the whole frame. Changes on the mode input during the rest of the frame have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | Scatter pattern, sampled with the frame start: 0 transmit, 1 receive |
| wr_valid | input | 1 | A block is present on wr_data |
| wr_sof | input | 1 | The present block is the first block of a frame |
| wr_data | input | 18 | Input block |
| rd_valid | output | 1 | An output block is available |
| rd_ready | input | 1 | The consumer takes the output block |
| rd_data | output | 18 | Output block |
| rd_last | output | 1 | The output block is the final block of its frame |
| ovr | output | 1 | One-cycle pulse: a frame start was refused because both stores were occupied |

## Verification
A fault in the scatter address walker shows up at the ports as blocks delivered at the wrong positions of the frame. The first misplaced block appears within a few transfers of the start of readout, in one cycle of the frame-segment stride, because both orderings are covered with random block contents. A store-select or occupancy flag that is out of step shows up in other ways: rd_valid rises one cycle early or late, a frame is repeated or lost, or ovr pulses when it should not. Each of these is seen no later than the next frame boundary. A read pointer that drifts under back-pressure shows up as data that changes during a stall, or as rd_last on the wrong transfer.

// File: rtl/blkx_pkg.sv
package blkx_pkg;

    localparam int BLK_W_DEF = 18;
    localparam int N_CW_DEF  = 60;
    localparam int N_SEG_DEF = 99;
    localparam int IDX_W     = 16;

    typedef enum logic {
        MODE_TX = 1'b0,
        MODE_RX = 1'b1
    } xmode_e;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_FILL = 1'b1
    } wstate_e;

    // Walk through the frame: inner loop length, outer loop length and the
    // address stride of one inner step.
    typedef struct packed {
        logic [IDX_W-1:0] len_in;
        logic [IDX_W-1:0] len_out;
        logic [IDX_W-1:0] stride;
    } walk_cfg_t;

    function automatic walk_cfg_t walk_cfg(xmode_e m, int n_cw, int n_seg);
        walk_cfg_t c;
        if (m == MODE_TX) begin
            c.len_in  = IDX_W'(n_seg);
            c.len_out = IDX_W'(n_cw);
            c.stride  = IDX_W'(n_cw);
        end else begin
            c.len_in  = IDX_W'(n_cw);
            c.len_out = IDX_W'(n_seg);
            c.stride  = IDX_W'(n_seg);
        end
        return c;
    endfunction

endpackage

// File: rtl/blkx_walk.sv
module blkx_walk
    import blkx_pkg::*;
#(
    parameter int N_CW  = N_CW_DEF,
    parameter int N_SEG = N_SEG_DEF,
    parameter int AW    = $clog2(N_CW_DEF * N_SEG_DEF)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          adv,
    input  xmode_e        mode_in,
    output logic [AW-1:0] cur_addr,
    output logic          cur_last
);

    localparam int TOTAL = N_CW * N_SEG;

    logic [IDX_W-1:0] in_r, out_r;
    logic [IDX_W-1:0] ci, co, ni, no;
    logic [AW-1:0]    addr_r, ca, na;
    xmode_e           mode_r, m;
    walk_cfg_t        cfg;
    logic             last_in;

    always_comb begin
        m       = restart ? mode_in : mode_r;
        cfg     = walk_cfg(m, N_CW, N_SEG);
        ci      = restart ? '0 : in_r;
        co      = restart ? '0 : out_r;
        ca      = restart ? '0 : addr_r;
        last_in = (ci == cfg.len_in - 1'b1);
        if (last_in) begin
            ni = '0;
            no = co + 1'b1;
            na = AW'(co + 1'b1);
        end else begin
            ni = ci + 1'b1;
            no = co;
            na = ca + AW'(cfg.stride);
        end
    end

    assign cur_addr = ca;
    assign cur_last = last_in && (co == cfg.len_out - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_r   <= '0;
            out_r  <= '0;
            addr_r <= '0;
            mode_r <= MODE_TX;
        end else if (adv) begin
            in_r   <= ni;
            out_r  <= no;
            addr_r <= na;
            mode_r <= m;
        end
    end

    // R2 R3: every scattered write lands inside the frame store
    assert_addr_range_R2: assert property (@(posedge clk) disable iff (rst)
        adv |-> (cur_addr < AW'(TOTAL)));

endmodule

// File: rtl/blkx_dpram.sv
module blkx_dpram #(
    parameter int W     = 18,
    parameter int DEPTH = 5940,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/blkx_rdctl.sv
module blkx_rdctl #(
    parameter int DEPTH = 5940,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    full_i,
    input  logic          ready,
    output logic          valid,
    output logic          last,
    output logic          sel,
    output logic [AW-1:0] ptr,
    output logic          done
);

    logic at_end, fire;

    assign valid  = full_i[sel];
    assign at_end = (ptr == AW'(DEPTH - 1));
    assign last   = valid && at_end;
    assign fire   = valid && ready;
    assign done   = fire && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= 1'b0;
            ptr <= '0;
        end else if (fire) begin
            if (at_end) begin
                ptr <= '0;
                sel <= ~sel;
            end else begin
                ptr <= ptr + AW'(1);
            end
        end
    end

    // R6: a stalled output keeps its position and stays offered
    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(ptr)));

endmodule

// File: rtl/blkx_pingpong.sv
module blkx_pingpong
    import blkx_pkg::*;
#(
    parameter int BLK_W = BLK_W_DEF,
    parameter int N_CW  = N_CW_DEF,
    parameter int N_SEG = N_SEG_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode,
    input  logic             wr_valid,
    input  logic             wr_sof,
    input  logic [BLK_W-1:0] wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [BLK_W-1:0] rd_data,
    output logic             rd_last,
    output logic             ovr
);

    localparam int DEPTH = N_CW * N_SEG;
    localparam int AW    = $clog2(DEPTH);
    localparam int NBUF  = 2;

    wstate_e          wst;
    logic             wsel;
    logic [1:0]       full;
    logic             idle, accept, restart, blocked, frame_done;
    logic [AW-1:0]    wr_addr, rptr;
    logic             wr_last, rsel, rd_done;
    logic [BLK_W-1:0] buf_q [NBUF];

    assign idle    = (wst == WR_IDLE);
    assign blocked = idle && wr_valid && wr_sof && full[wsel];
    assign accept  = wr_valid && (idle ? (wr_sof && !full[wsel]) : 1'b1);
    assign restart = accept && wr_sof;
    assign frame_done = accept && wr_last;

    blkx_walk #(
        .N_CW  (N_CW),
        .N_SEG (N_SEG),
        .AW    (AW)
    ) u_walk (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .adv      (accept),
        .mode_in  (xmode_e'(mode)),
        .cur_addr (wr_addr),
        .cur_last (wr_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wst  <= WR_IDLE;
            wsel <= 1'b0;
            ovr  <= 1'b0;
        end else begin
            ovr <= blocked;
            if (frame_done) begin
                wst  <= WR_IDLE;
                wsel <= ~wsel;
            end else if (accept) begin
                wst <= WR_FILL;
            end
        end
    end

    generate
        for (genvar b = 0; b < NBUF; b++) begin : g_buf
            always_ff @(posedge clk) begin
                if (rst) begin
                    full[b] <= 1'b0;
                end else if (frame_done && (wsel == 1'(b))) begin
                    full[b] <= 1'b1;
                end else if (rd_done && (rsel == 1'(b))) begin
                    full[b] <= 1'b0;
                end
            end

            blkx_dpram #(
                .W     (BLK_W),
                .DEPTH (DEPTH),
                .AW    (AW)
            ) u_store (
                .clk   (clk),
                .we    (accept && (wsel == 1'(b))),
                .waddr (wr_addr),
                .wdata (wr_data),
                .raddr (rptr),
                .rdata (buf_q[b])
            );
        end
    endgenerate

    blkx_rdctl #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_rd (
        .clk    (clk),
        .rst    (rst),
        .full_i (full),
        .ready  (rd_ready),
        .valid  (rd_valid),
        .last   (rd_last),
        .sel    (rsel),
        .ptr    (rptr),
        .done   (rd_done)
    );

    assign rd_data = buf_q[rsel];

    // R10: the writer never fills a store that still holds an unread frame
    assert_no_fill_full_R10: assert property (@(posedge clk) disable iff (rst)
        accept |-> !full[wsel]);

    // R10: a refused start is only flagged when both stores are occupied
    assert_ovr_both_full_R10: assert property (@(posedge clk) disable iff (rst)
        ovr |-> ($past(full) == 2'b11));

    // R6: stalled output data does not move
    assert_hold_data_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R9: after the final transfer of a frame its store is released
    assert_release_after_last_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ready && rd_last) |=> ($past(rsel) ? !full[1] : !full[0]));

endmodule

// File: tb/blkx_pingpong_tb.sv
module blkx_pingpong_tb;

    localparam int CLK_PERIOD = 10;
    localparam int BW    = 18;
    localparam int NCW   = 60;
    localparam int NSEG  = 99;
    localparam int DEPTH = NCW * NSEG;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode = 1'b0;
    logic          wr_valid = 1'b0;
    logic          wr_sof = 1'b0;
    logic [BW-1:0] wr_data = '0;
    logic          rd_valid;
    logic          rd_ready = 1'b0;
    logic [BW-1:0] rd_data;
    logic          rd_last;
    logic          ovr;

    int unsigned exp_q[$];
    string       tag_q[$];
    int          vecs = 0;
    int          fails = 0;
    int          out_cnt = 0;
    int          out_pos = 0;
    int          ovr_cnt = 0;
    bit          rdy_en = 1'b0;
    bit          prev_stall = 1'b0;
    logic [BW-1:0] prev_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blkx_pingpong u_dut (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .wr_valid (wr_valid),
        .wr_sof   (wr_sof),
        .wr_data  (wr_data),
        .rd_valid (rd_valid),
        .rd_ready (rd_ready),
        .rd_data  (rd_data),
        .rd_last  (rd_last),
        .ovr      (ovr)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Output position of input position k for a given mode
    function automatic int out_pos_of(bit m, int k);
        if (m == 1'b0) return (k % NSEG) * NCW + k / NSEG;
        else           return (k % NCW) * NSEG + k / NCW;
    endfunction

    // Consumer back-pressure
    always @(posedge clk) begin
        #1;
        rd_ready = rdy_en ? ($urandom_range(3, 0) != 0) : 1'b0;
    end

    // Output monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall) begin
                chk(rd_valid && (rd_data == prev_data), "R6", "stalled output changed",
                    int'(rd_data), int'(prev_data));
            end
            if (rd_valid && rd_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10", "block delivered with none expected", int'(rd_data), 0);
                end else begin
                    int unsigned e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(rd_data == BW'(e), t, "block value", int'(rd_data), int'(e));
                    chk(rd_last == (out_pos == DEPTH - 1), "R5", "last flag",
                        int'(rd_last), int'(out_pos == DEPTH - 1));
                end
                out_pos = (out_pos == DEPTH - 1) ? 0 : out_pos + 1;
                out_cnt++;
            end
            prev_stall = rd_valid && !rd_ready;
            prev_data  = rd_data;
            if (ovr) ovr_cnt++;
        end
    end

    task automatic send(bit m, int n, bit gaps, bit toggle, bit chk_av, string tag);
        int unsigned d[DEPTH];
        int unsigned e[DEPTH];
        for (int k = 0; k < n; k++) begin
            if (gaps) begin
                while ($urandom_range(5, 0) == 0) begin
                    @(posedge clk); #1;
                    wr_valid = 1'b0;
                    wr_sof   = 1'b0;
                    if (toggle) mode = 1'($urandom_range(1, 0));
                end
            end
            @(posedge clk); #1;
            d[k]     = $urandom & 32'h3ffff;
            wr_valid = 1'b1;
            wr_sof   = (k == 0);
            wr_data  = BW'(d[k]);
            mode     = (k == 0) ? m : (toggle ? 1'($urandom_range(1, 0)) : m);
            if (chk_av && k == n - 1) begin
                @(negedge clk);
                chk(rd_valid == 1'b0, "R4", "valid before final block written", int'(rd_valid), 0);
            end
        end
        @(posedge clk); #1;
        wr_valid = 1'b0;
        wr_sof   = 1'b0;
        if (n == DEPTH) begin
            for (int k = 0; k < DEPTH; k++) e[out_pos_of(m, k)] = d[k];
            for (int p = 0; p < DEPTH; p++) begin
                exp_q.push_back(e[p]);
                tag_q.push_back(tag);
            end
        end
    endtask

    task automatic run_all();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(rd_valid == 1'b0, "R1", "rd_valid after reset", int'(rd_valid), 0);
        chk(rd_last == 1'b0, "R1", "rd_last after reset", int'(rd_last), 0);
        chk(ovr == 1'b0, "R1", "ovr after reset", int'(ovr), 0);

        // R7: blocks without a frame start are dropped
        for (int k = 0; k < 5; k++) begin
            @(posedge clk); #1;
            wr_valid = 1'b1;
            wr_sof   = 1'b0;
            wr_data  = BW'($urandom);
        end
        @(posedge clk); #1 wr_valid = 1'b0;
        @(negedge clk);
        chk(rd_valid == 1'b0, "R7", "valid after blocks without start", int'(rd_valid), 0);

        // Frame A, transmit, reader stalled
        send(1'b0, DEPTH, 1'b0, 1'b0, 1'b1, "R2");
        @(negedge clk);
        chk(rd_valid == 1'b1, "R4", "valid after final block written", int'(rd_valid), 1);

        // Frame B, receive, into the second store
        send(1'b1, DEPTH, 1'b1, 1'b0, 1'b0, "R3");

        // Frame C offered with both stores occupied
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_sof = 1'b1; wr_data = BW'($urandom);
        @(negedge clk);
        chk(ovr == 1'b0, "R10", "ovr in start cycle", int'(ovr), 0);
        @(posedge clk); #1 wr_sof = 1'b0;
        @(negedge clk);
        chk(ovr == 1'b1, "R10", "ovr cycle after refused start", int'(ovr), 1);
        for (int k = 0; k < 20; k++) begin
            @(posedge clk); #1 wr_data = BW'($urandom);
        end
        @(posedge clk); #1 wr_valid = 1'b0;
        @(negedge clk);
        chk(ovr == 1'b0, "R10", "ovr after refused frame", int'(ovr), 0);

        rdy_en = 1'b1;
        while (out_cnt < DEPTH) @(posedge clk);

        // R8: partial frame in receive mode, then restart with transmit
        send(1'b1, 300, 1'b1, 1'b0, 1'b0, "R8");
        send(1'b0, DEPTH, 1'b1, 1'b1, 1'b0, "R8");

        while (out_cnt < 2 * DEPTH) @(posedge clk);
        // Frame E written while frame D is read; mode wiggles mid-frame
        send(1'b1, DEPTH, 1'b1, 1'b1, 1'b0, "R11");

        while (out_cnt < 4 * DEPTH) @(posedge clk);
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(out_cnt == 4 * DEPTH, "R9", "blocks delivered", out_cnt, 4 * DEPTH);
        chk(exp_q.size() == 0, "R9", "undelivered expected blocks", exp_q.size(), 0);
        chk(rd_valid == 1'b0, "R9", "valid after all frames drained", int'(rd_valid), 0);
        chk(ovr_cnt == 1, "R10", "ovr pulse count", ovr_cnt, 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                fails++;
                vecs++;
                $display("FAIL R9 watchdog expired actual=%0d expected=%0d", out_cnt, 4 * DEPTH);
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule